// File: doc/BRIEF.md
# Sweep Sequencer With Threshold Result Queue

This block drives a conversion engine through a programmed list of channels from a single trigger. For each list entry it raises a one-cycle start request with the channel number on a select output and then waits for the engine's done pulse. When the pulse arrives, the returned 14-bit result and its channel number are written into an eight-entry first-in first-out result queue.

The host drains the queue with single-cycle read requests. Each accepted read removes the oldest entry. The host is interrupted through an active-low line once the number of stored results reaches a programmable fill threshold. A configuration write selects the channel list and the threshold, aborts any sweep in progress and empties the queue. A later trigger may start a new sweep while older results are still waiting to be read. The new results are then appended behind them.

Top module: `sweep_seq_top`

## Requirements
- R1: After reset, irq_n is 1, ovf_flag is 0, rd_data and rd_chan are 0, conv_start is 0 and the queue is empty.
- R2: The list field cfg_list_sel selects the channel order of a sweep: 0 gives channels 0,3; 1 gives 0,2,0,2; 2 gives 0,1,2,3; 3 gives 0 through 7 ascending. Each list entry produces exactly one conv_start pulse, one cycle wide, with conv_chan holding that entry's channel. The next pulse follows the cycle after the previous conv_done.
- R3: A sweep_trig that arrives while a sweep is in progress, from the accepted trigger until the last done, is ignored and starts no further conversions.
- R4: Every conv_done taken during a sweep stores {channel, conv_data}. Reads return the entries oldest first. rd_data and rd_chan are updated in the cycle after the rd_req cycle.
- R5: The threshold field cfg_thr_sel encodes the fill level: 0→1, 1→2, 2→4, 3→8. irq_n falls one cycle after the fill level first reaches the threshold.
- R6: irq_n returns high when the first read after its assertion is accepted. It asserts again only after the fill level has dropped below the threshold and then reached it again.
- R7: A result that arrives while the queue holds 8 entries and no read is accepted is dropped, and ovf_flag goes to 1. ovf_flag stays at 1 until the next configuration write.
- R8: A cfg_wr empties the queue, clears ovf_flag and the interrupt, aborts a running sweep, and latches the new list and threshold fields for later sweeps. A trigger in the same cycle is ignored.
- R9: A read of an empty queue returns rd_data = 0 and rd_chan = 0 and leaves the queue order intact, so the next stored result is the next one read.
- R10: A trigger given after a sweep completes starts a new sweep even when the queue still holds earlier results. The new results are appended behind the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_list_sel | input | 2 | Channel list selector, latched on cfg_wr |
| cfg_thr_sel | input | 2 | Interrupt threshold selector, latched on cfg_wr |
| sweep_trig | input | 1 | Starts a sweep when idle |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the current conversion |
| conv_done | input | 1 | Conversion finished, conv_data valid |
| conv_data | input | 14 | Conversion result |
| rd_req | input | 1 | Host read request, one entry per cycle |
| rd_data | output | 14 | Result of the last read |
| rd_chan | output | 3 | Channel tag of the last read |
| irq_n | output | 1 | Active-low threshold interrupt |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest case to reach is the overflow. The queue has to be filled completely and another whole sweep then pushed with no read in between, because any accepted read frees a slot. The bench runs the eight-channel list twice while holding rd_req low. It then drains the queue and checks that only the first sweep's tags come back. It also reads once past empty and confirms that a third sweep is read back correctly. A second hard case is the configuration write in the middle of a sweep, while a conversion is still in flight. The bench times the write a few cycles after the trigger. It then checks that the late done pulse is not stored and that no further start pulses appear.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;

  localparam int LIST_SEL_W = 2;
  localparam int THR_SEL_W  = 2;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_START = 2'd1,
    WK_WAIT  = 2'd2
  } walk_st_e;

  // number of conversions in the list picked by sel
  function automatic int sweep_len(input logic [LIST_SEL_W-1:0] sel, input int nch);
    case (sel)
      2'd0:    sweep_len = 2;
      2'd1:    sweep_len = 4;
      2'd2:    sweep_len = 4;
      default: sweep_len = nch;
    endcase
  endfunction

  // channel at position idx of the list picked by sel
  function automatic int sweep_chan(input logic [LIST_SEL_W-1:0] sel, input int idx);
    case (sel)
      2'd0:    sweep_chan = (idx == 0) ? 0 : 3;
      2'd1:    sweep_chan = ((idx % 2) == 0) ? 0 : 2;
      default: sweep_chan = idx;
    endcase
  endfunction

endpackage

// File: rtl/sweep_walker.sv
module sweep_walker
  import sweep_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic [LIST_SEL_W-1:0] list_sel,
  input  logic                  trig,
  input  logic                  conv_done,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_chan,
  output logic                  push
);

  walk_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_entry;

  assign last_entry = (idx_q == IDX_W'(sweep_len(list_sel, NCH) - 1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (abort) begin
      st_d  = WK_IDLE;
      idx_d = '0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (trig) begin
            st_d  = WK_START;
            idx_d = '0;
          end
        end
        WK_START: st_d = WK_WAIT;
        WK_WAIT: begin
          if (conv_done) begin
            if (last_entry) begin
              st_d = WK_IDLE;
            end else begin
              st_d  = WK_START;
              idx_d = idx_q + 1'b1;
            end
          end
        end
        default: st_d = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign conv_start = (st_q == WK_START);
  assign conv_chan  = CH_W'(sweep_chan(list_sel, int'(idx_q)));
  assign push       = (st_q == WK_WAIT) && conv_done && !abort;

endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 17,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] fill,
  output logic             pop_ok,
  output logic             overflow
);

  logic [PTR_W-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [W-1:0]       rd_q, rd_d;
  logic               ovf_q, ovf_d;
  logic               full, push_ok;
  logic [DEPTH*W-1:0] ent_flat;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_req && (cnt_q != '0) && !clr;
  assign push_ok = push && !clr && (!full || pop_ok);

  // storage: one register per slot, each with its own write enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (push_ok && (wptr_q == PTR_W'(e))) begin
        ent_q <= push_data;
      end
    end
    assign ent_flat[e*W +: W] = ent_q;
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    ovf_d  = ovf_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end else begin
      if (push_ok) begin
        wptr_d = wptr_q + 1'b1;
      end
      if (push && !push_ok) begin
        ovf_d = 1'b1;
      end
      if (pop_req) begin
        rd_d = pop_ok ? ent_flat[rptr_q*W +: W] : '0;
      end
      if (pop_ok) begin
        rptr_d = rptr_q + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      ovf_q  <= ovf_d;
    end
  end

  assign rd_data  = rd_q;
  assign fill     = cnt_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/fill_irq.sv
module fill_irq
  import sweep_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [THR_SEL_W-1:0] thr_sel,
  input  logic [CNT_W-1:0]     fill,
  input  logic                 pop_ok,
  output logic                 irq_n
);

  logic [CNT_W-1:0] thr;
  logic             reach;
  logic             act_q, act_d, arm_q, arm_d;

  always_comb begin
    thr = CNT_W'(1) << thr_sel;
    if (thr > CNT_W'(DEPTH)) begin
      thr = CNT_W'(DEPTH);
    end
  end

  assign reach = (fill >= thr);

  always_comb begin
    act_d = act_q;
    arm_d = arm_q;
    if (clr) begin
      act_d = 1'b0;
      arm_d = 1'b1;
    end else if (act_q) begin
      if (pop_ok) begin
        act_d = 1'b0;
      end
    end else if (arm_q) begin
      if (reach) begin
        act_d = 1'b1;
        arm_d = 1'b0;
      end
    end else if (!reach) begin
      arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      arm_q <= 1'b1;
    end else begin
      act_q <= act_d;
      arm_q <= arm_d;
    end
  end

  assign irq_n = ~act_q;

endmodule

// File: rtl/sweep_seq_top.sv
module sweep_seq_top
  import sweep_seq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DATA_W = 14,
  parameter int DEPTH  = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = CH_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [LIST_SEL_W-1:0] cfg_list_sel,
  input  logic [THR_SEL_W-1:0]  cfg_thr_sel,
  input  logic                  sweep_trig,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_chan,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic                  rd_req,
  output logic [DATA_W-1:0]     rd_data,
  output logic [CH_W-1:0]       rd_chan,
  output logic                  irq_n,
  output logic                  ovf_flag
);

  logic [1:0]            rst_sync_q;
  logic                  rst_core_n;
  logic [LIST_SEL_W-1:0] list_q;
  logic [THR_SEL_W-1:0]  thr_q;
  logic                  push_w, pop_ok_w;
  logic [CNT_W-1:0]      fill_w;
  logic [ENT_W-1:0]      rd_ent_w;

  // reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      list_q <= '0;
      thr_q  <= '0;
    end else if (cfg_wr) begin
      list_q <= cfg_list_sel;
      thr_q  <= cfg_thr_sel;
    end
  end

  sweep_walker #(.NCH(NCH)) walker_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .abort      (cfg_wr),
    .list_sel   (list_q),
    .trig       (sweep_trig),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .push       (push_w)
  );

  result_fifo #(.DEPTH(DEPTH), .W(ENT_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (cfg_wr),
    .push      (push_w),
    .push_data ({conv_chan, conv_data}),
    .pop_req   (rd_req),
    .rd_data   (rd_ent_w),
    .fill      (fill_w),
    .pop_ok    (pop_ok_w),
    .overflow  (ovf_flag)
  );

  fill_irq #(.DEPTH(DEPTH)) irq_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (cfg_wr),
    .thr_sel (thr_q),
    .fill    (fill_w),
    .pop_ok  (pop_ok_w),
    .irq_n   (irq_n)
  );

  assign rd_chan = rd_ent_w[ENT_W-1 -: CH_W];
  assign rd_data = rd_ent_w[DATA_W-1:0];

endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk #(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 3,
  parameter int DATA_W = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              conv_start,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic [CH_W-1:0]   rd_chan,
  input logic              irq_n,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  fill
);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cfg_wr) |=> ovf_flag);

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (fill == '0) && !cfg_wr) |=> ((rd_data == '0) && (rd_chan == '0)));

  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && rd_req && (fill != '0) && !cfg_wr) |=> irq_n);

  // R8
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((fill == '0) && !ovf_flag && irq_n));

endmodule

bind sweep_seq_top sweep_seq_chk #(.DEPTH(DEPTH), .CH_W(CH_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .conv_start (conv_start),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .rd_chan    (rd_chan),
  .irq_n      (irq_n),
  .ovf_flag   (ovf_flag),
  .fill       (fill_w)
);

// File: tb/sweep_seq_top_tb_top.sv
module sweep_seq_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_list_sel;
  logic [1:0]  cfg_thr_sel;
  logic        sweep_trig;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done;
  logic [13:0] conv_data;
  logic        rd_req;
  logic [13:0] rd_data;
  logic [2:0]  rd_chan;
  logic        irq_n;
  logic        ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  // engine model state
  int eng_busy = 0;
  int eng_cnt  = 0;
  int next_tag = 100;
  int done_cnt = 0;
  int log_n    = 0;
  int chan_log [0:255];

  sweep_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_list_sel(cfg_list_sel),
    .cfg_thr_sel(cfg_thr_sel), .sweep_trig(sweep_trig), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .rd_req(rd_req), .rd_data(rd_data), .rd_chan(rd_chan), .irq_n(irq_n),
    .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // conversion engine: done three negedges after it sees a start
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (eng_busy != 0) begin
      if (eng_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = 14'(next_tag);
        next_tag  = next_tag + 1;
        done_cnt  = done_cnt + 1;
        eng_busy  = 0;
      end else begin
        eng_cnt = eng_cnt - 1;
      end
    end else if (conv_start === 1'b1) begin
      chan_log[log_n] = int'(conv_chan);
      log_n    = log_n + 1;
      eng_busy = 1;
      eng_cnt  = 2;
    end
  end

  function automatic int exp_len(input int sel);
    if (sel == 0) return 2;
    if (sel == 3) return 8;
    return 4;
  endfunction

  function automatic int exp_chan(input int sel, input int i);
    if (sel == 0) return (i == 0) ? 0 : 3;
    if (sel == 1) return (i % 2 == 0) ? 0 : 2;
    return i;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int lst, input int thr);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_list_sel = 2'(lst); cfg_thr_sel = 2'(thr);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    sweep_trig = 1'b1;
    @(negedge clk);
    sweep_trig = 1'b0;
  endtask

  task automatic fire_wait(input int n);
    int target;
    target = done_cnt + n;
    pulse_trig();
    while (done_cnt < target) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_one(output int ch, output int dat);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    ch  = int'(rd_chan);
    dat = int'(rd_data);
  endtask

  task automatic t_reset();
    int ch, dat;
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    read_one(ch, dat);
    chk("R1 empty after reset", dat, 0);
  endtask

  task automatic t_list(input int sel);
    int base_log, base_tag, ch, dat;
    do_cfg(sel, 3);
    base_log = log_n;
    base_tag = next_tag;
    fire_wait(exp_len(sel));
    chk("R2 start count", log_n - base_log, exp_len(sel));
    for (int i = 0; i < exp_len(sel); i++) begin
      chk("R2 channel order", chan_log[base_log + i], exp_chan(sel, i));
    end
    for (int i = 0; i < exp_len(sel); i++) begin
      read_one(ch, dat);
      chk("R4 read channel", ch, exp_chan(sel, i));
      chk("R4 read data", dat, base_tag + i);
    end
  endtask

  task automatic t_latency();
    int ch, dat;
    do_cfg(0, 0);
    pulse_trig();
    do @(posedge clk); while (conv_done !== 1'b1);
    @(negedge clk);
    chk("R5 irq not yet", int'(irq_n), 1);
    @(negedge clk);
    chk("R5 irq one cycle later", int'(irq_n), 0);
    while (log_n < 0) @(posedge clk);
    repeat (12) @(negedge clk);
    read_one(ch, dat);
    chk("R6 release on read", int'(irq_n), 1);
    repeat (3) @(negedge clk);
    chk("R6 no reassert above thr", int'(irq_n), 1);
    read_one(ch, dat);
  endtask

  task automatic t_repeat();
    int base_tag, ch, dat;
    do_cfg(0, 2);
    base_tag = next_tag;
    fire_wait(2);
    chk("R5 below thr 4", int'(irq_n), 1);
    fire_wait(2);
    chk("R10 second sweep reaches thr", int'(irq_n), 0);
    for (int i = 0; i < 4; i++) begin
      read_one(ch, dat);
      chk("R10 appended order", dat, base_tag + i);
      if (i == 0) chk("R6 release", int'(irq_n), 1);
    end
  endtask

  task automatic t_rearm();
    int ch, dat;
    do_cfg(0, 1);
    fire_wait(2);
    chk("R5 thr 2 reached", int'(irq_n), 0);
    read_one(ch, dat);
    read_one(ch, dat);
    repeat (2) @(negedge clk);
    chk("R6 quiet when empty", int'(irq_n), 1);
    fire_wait(2);
    chk("R6 re-assert", int'(irq_n), 0);
  endtask

  task automatic t_busy();
    int base_log, target;
    do_cfg(2, 3);
    base_log = log_n;
    target   = done_cnt + 4;
    pulse_trig();
    repeat (3) @(negedge clk);
    pulse_trig();
    repeat (4) @(negedge clk);
    pulse_trig();
    while (done_cnt < target) @(posedge clk);
    repeat (20) @(negedge clk);
    chk("R3 extra trig ignored", log_n - base_log, 4);
  endtask

  task automatic t_overflow();
    int base1, base3, ch, dat;
    do_cfg(3, 3);
    base1 = next_tag;
    fire_wait(8);
    chk("R7 full no ovf", int'(ovf_flag), 0);
    fire_wait(8);
    chk("R7 ovf set", int'(ovf_flag), 1);
    for (int i = 0; i < 8; i++) begin
      read_one(ch, dat);
      chk("R7 dropped newest", dat, base1 + i);
    end
    read_one(ch, dat);
    chk("R9 empty data", dat, 0);
    chk("R9 empty chan", ch, 0);
    chk("R7 sticky", int'(ovf_flag), 1);
    base3 = next_tag;
    fire_wait(8);
    read_one(ch, dat);
    chk("R9 order kept", dat, base3);
    do_cfg(0, 0);
    chk("R8 ovf cleared", int'(ovf_flag), 0);
    read_one(ch, dat);
    chk("R8 queue emptied", dat, 0);
  endtask

  task automatic t_abort();
    int snap, base_log, ch, dat;
    do_cfg(3, 3);
    pulse_trig();
    repeat (6) @(negedge clk);
    do_cfg(1, 0);
    snap = log_n;
    repeat (30) @(negedge clk);
    chk("R8 sweep aborted", log_n, snap);
    chk("R8 irq idle", int'(irq_n), 1);
    read_one(ch, dat);
    chk("R8 nothing stored", dat, 0);
    base_log = log_n;
    fire_wait(4);
    chk("R8 new list ch1", chan_log[base_log + 1], 2);
    chk("R8 new list ch3", chan_log[base_log + 3], 2);
    chk("R8 new thr 1", int'(irq_n), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_list_sel = 2'd0; cfg_thr_sel = 2'd0;
    sweep_trig = 1'b0; rd_req = 1'b0; conv_done = 1'b0; conv_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    for (int s = 0; s < 4; s++) t_list(s);
    t_latency();
    t_repeat();
    t_rearm();
    t_busy();
    t_overflow();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule